// File: doc/BRIEF.md
# Rate-Limited Password Unlock Guard

This block guards a global protection lock with a 64-bit password held as four 16-bit words. A host on a 16-bit command port can program the password, read it back while programming is still allowed, seal it for good, and present unlock attempts. Programming behaves like a one-way cell: bits may only go from 1 to 0. An attempt to raise a bit leaves the bit at 0 and reports an error.

An unlock attempt is four word writes. Once the fourth word arrives, the block compares all 64 bits at once. It gives no partial result. After every attempt, passed or failed, the block holds off further unlock writes for one microsecond, counted as `CLK_PER_US` clock cycles. An attempt that passes produces a single-cycle clear pulse toward the protection lock bit at the end of that same interval. A sealed password can still be used to unlock. It can no longer be read or changed. Only the synchronous reset, which stands for power-up, restores the erased password and the unsealed state.

Top module: `pwd_guard`

## Requirements
- R1: While and after `rst`, every stored word reads as 16'hFFFF, the mode is unsealed, and `busy`, `prog_err` and `unlock_clr` are 0.
- R2: A program command (`cmd_op` = 0) on an unsealed block replaces the word at `cmd_addr` with its old value ANDed with `cmd_data`. Words may be programmed in any address order, and no stored bit ever goes from 0 to 1.
- R3: The cycle after a program command on an unsealed block, `prog_err` is 1 for one cycle exactly when `cmd_data` has a 1 where the stored word has a 0. Otherwise `prog_err` stays 0.
- R4: A read command (`cmd_op` = 1) on an unsealed block puts the word at `cmd_addr` on `rd_data` from the next cycle, and `rd_data` holds that value until the next read.
- R5: A seal command (`cmd_op` = 3) sets the mode-lock for good, until `rst`. After it, reads return 16'h0000, program commands change nothing and never raise `prog_err`, and unlocking still works against the unchanged password.
- R6: An unlock word is a command with `cmd_op` = 2 that arrives while `busy` is 0. The fourth such word ends an attempt. If the four words cover all four addresses and each word equals its stored word, `unlock_clr` is 1 for exactly one cycle, registered on the `CLK_PER_US`-th rising edge after the edge that took the fourth word.
- R7: An attempt in which any word differs from its stored word, or which repeats an address and so leaves one out, produces no `unlock_clr` pulse.
- R8: Every completed attempt, whether it passes or fails, holds `busy` at 1 for exactly `CLK_PER_US` cycles starting the cycle after its fourth word. Unlock words that arrive while `busy` is 1 are dropped and count toward no attempt.
- R9: A program, read or seal command that arrives while an attempt is partly collected throws that attempt away. The words already taken are discarded, and no hold-off starts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, models power-up |
| cmd_valid | input | 1 | Command strobe, one command per cycle |
| cmd_op | input | 2 | 0 program, 1 read, 2 unlock word, 3 seal |
| cmd_addr | input | 2 | Password word select |
| cmd_data | input | 16 | Program data or unlock word |
| rd_data | output | 16 | Last read result |
| busy | output | 1 | Unlock hold-off in progress |
| prog_err | output | 1 | One-cycle pulse: program tried to raise a bit |
| unlock_clr | output | 1 | One-cycle pulse that clears the protection lock bit |

## Verification
The bench programs the password with a sweep of patterns in a scrambled address order. Some patterns only clear bits and others try to raise them. This catches a store that overwrites instead of ANDing, and an error flag that fires on the wrong condition. It times the unlock pulse and the busy window cycle by cycle, so an off-by-one in the pacing counter shows up as a wrong pulse cycle or busy length. It sends unlock words during the hold-off, attempts with a repeated address, and attempts cut short by another command. A design that counted dropped words, accepted an attempt with a duplicate address, or kept a partial attempt would then unlock or go busy where it must not. After sealing, the bench checks that reads come back blank and that programming leaves the password intact, which it confirms by unlocking with the old password.

// File: rtl/pwd_guard_pkg.sv
package pwd_guard_pkg;

    localparam int WORD_W  = 16;
    localparam int NWORDS  = 4;
    localparam int ADDR_W  = $clog2(NWORDS);
    localparam int PASS_W  = WORD_W * NWORDS;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [ADDR_W-1:0] waddr_t;

    typedef enum logic [1:0] {
        OP_PROG   = 2'd0,
        OP_READ   = 2'd1,
        OP_UNLOCK = 2'd2,
        OP_SEAL   = 2'd3
    } op_e;

    typedef struct packed {
        logic   valid;
        op_e    op;
        waddr_t addr;
        word_t  data;
    } cmd_t;

    // True when the new data asks for a 1 where the cell already holds 0.
    function automatic logic raises_bit(word_t old_w, word_t new_w);
        return |(new_w & ~old_w);
    endfunction

    // Bit mask with a single bit set at the given word address.
    function automatic logic [NWORDS-1:0] addr_mask(waddr_t a);
        logic [NWORDS-1:0] m;
        m = '0;
        m[a] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/pwd_store.sv
module pwd_store
    import pwd_guard_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  cmd_t                      cmd,
    output word_t [NWORDS-1:0]        words,
    output word_t                     rdata,
    output logic                      prog_err,
    output logic                      sealed
);

    word_t [NWORDS-1:0] words_q;
    logic               sealed_q;
    word_t              rdata_q;
    logic               err_q;

    logic prog_go;
    logic read_go;
    logic seal_go;

    assign prog_go = cmd.valid && (cmd.op == OP_PROG) && !sealed_q;
    assign read_go = cmd.valid && (cmd.op == OP_READ);
    assign seal_go = cmd.valid && (cmd.op == OP_SEAL);

    // One register per password word; only clearing of bits is possible.
    for (genvar gi = 0; gi < NWORDS; gi++) begin : g_word
        logic hit;
        assign hit = prog_go && (cmd.addr == waddr_t'(gi));
        always_ff @(posedge clk) begin
            if (rst) begin
                words_q[gi] <= '1;
            end else if (hit) begin
                words_q[gi] <= words_q[gi] & cmd.data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sealed_q <= 1'b0;
            rdata_q  <= '0;
            err_q    <= 1'b0;
        end else begin
            err_q <= prog_go && raises_bit(words_q[cmd.addr], cmd.data);
            if (seal_go) begin
                sealed_q <= 1'b1;
            end
            if (read_go) begin
                rdata_q <= sealed_q ? word_t'('0) : words_q[cmd.addr];
            end
        end
    end

    assign words    = words_q;
    assign rdata    = rdata_q;
    assign prog_err = err_q;
    assign sealed   = sealed_q;

endmodule

// File: rtl/pwd_attempt.sv
module pwd_attempt
    import pwd_guard_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  cmd_t                 cmd,
    input  word_t [NWORDS-1:0]   words,
    input  logic                 busy,
    output logic                 done,
    output logic                 pass
);

    logic [NWORDS-1:0] seen_q;
    logic [NWORDS-1:0] hit_q;
    waddr_t            idx_q;

    logic              take;
    logic              abort;
    logic [NWORDS-1:0] seen_n;
    logic [NWORDS-1:0] hit_n;
    logic              match;

    assign take  = cmd.valid && (cmd.op == OP_UNLOCK) && !busy;
    assign abort = cmd.valid && (cmd.op != OP_UNLOCK);
    assign match = (cmd.data == words[cmd.addr]);

    always_comb begin
        seen_n = seen_q | addr_mask(cmd.addr);
        hit_n  = hit_q;
        if (match) begin
            hit_n = hit_q | addr_mask(cmd.addr);
        end
    end

    // The whole verdict is formed only on the last word: no partial result leaks.
    assign done = take && (idx_q == waddr_t'(NWORDS - 1));
    assign pass = (&seen_n) && (&hit_n);

    always_ff @(posedge clk) begin
        if (rst || abort || done) begin
            seen_q <= '0;
            hit_q  <= '0;
            idx_q  <= '0;
        end else if (take) begin
            seen_q <= seen_n;
            hit_q  <= hit_n;
            idx_q  <= idx_q + waddr_t'(1);
        end
    end

endmodule

// File: rtl/pwd_pacer.sv
module pwd_pacer #(
    parameter int CLK_PER_US = 125
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic good,
    output logic busy,
    output logic fire
);

    localparam int CW = $clog2(CLK_PER_US + 1);

    logic [CW-1:0] cnt_q;
    logic          pend_q;
    logic          fire_q;
    logic          last;

    assign last = (cnt_q == CW'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            pend_q <= 1'b0;
            fire_q <= 1'b0;
        end else begin
            fire_q <= pend_q && last;
            if (start) begin
                cnt_q  <= CW'(CLK_PER_US);
                pend_q <= good;
            end else if (cnt_q != '0) begin
                cnt_q <= cnt_q - CW'(1);
                if (last) begin
                    pend_q <= 1'b0;
                end
            end
        end
    end

    assign busy = (cnt_q != '0);
    assign fire = fire_q;

endmodule

// File: rtl/pwd_guard.sv
module pwd_guard
    import pwd_guard_pkg::*;
#(
    parameter int CLK_PER_US = 125
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cmd_valid,
    input  logic [1:0]  cmd_op,
    input  logic [1:0]  cmd_addr,
    input  logic [15:0] cmd_data,
    output logic [15:0] rd_data,
    output logic        busy,
    output logic        prog_err,
    output logic        unlock_clr
);

    cmd_t               cmd;
    word_t [NWORDS-1:0] words_w;
    logic [PASS_W-1:0]  words_flat_w;
    logic               sealed_w;
    logic               att_done;
    logic               att_pass;
    logic               busy_w;

    assign cmd.valid = cmd_valid;
    assign cmd.op    = op_e'(cmd_op);
    assign cmd.addr  = waddr_t'(cmd_addr);
    assign cmd.data  = word_t'(cmd_data);

    assign words_flat_w = words_w;

    pwd_store u_store (
        .clk      (clk),
        .rst      (rst),
        .cmd      (cmd),
        .words    (words_w),
        .rdata    (rd_data),
        .prog_err (prog_err),
        .sealed   (sealed_w)
    );

    pwd_attempt u_attempt (
        .clk   (clk),
        .rst   (rst),
        .cmd   (cmd),
        .words (words_w),
        .busy  (busy_w),
        .done  (att_done),
        .pass  (att_pass)
    );

    pwd_pacer #(.CLK_PER_US(CLK_PER_US)) u_pacer (
        .clk   (clk),
        .rst   (rst),
        .start (att_done),
        .good  (att_pass),
        .busy  (busy_w),
        .fire  (unlock_clr)
    );

    assign busy = busy_w;

endmodule

// File: rtl/pwd_guard_chk.sv
module pwd_guard_chk #(
    parameter int CLK_PER_US = 125
) (
    input logic        clk,
    input logic        rst,
    input logic        cmd_valid,
    input logic [1:0]  cmd_op,
    input logic [15:0] rd_data,
    input logic        busy,
    input logic        prog_err,
    input logic        unlock_clr,
    input logic        sealed,
    input logic [63:0] words_flat
);

    int run_q;

    always_ff @(posedge clk) begin
        if (rst) run_q <= 0;
        else if (busy) run_q <= run_q + 1;
        else run_q <= 0;
    end

    AST_NO_NEW_ONES: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((words_flat & ~$past(words_flat)) == 64'h0)); // R2

    AST_ERR_FROM_PROG: assert property (@(posedge clk) disable iff (rst)
        prog_err |-> $past(cmd_valid && cmd_op == 2'd0 && !sealed)); // R3

    AST_SEAL_STICKY: assert property (@(posedge clk) disable iff (rst)
        sealed |=> sealed); // R5

    AST_SEALED_READ_BLANK: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == 2'd1 && sealed) |=> (rd_data == 16'h0)); // R5

    AST_SEALED_FROZEN: assert property (@(posedge clk) disable iff (rst)
        sealed |=> $stable(words_flat)); // R5

    AST_CLEAR_SINGLE: assert property (@(posedge clk) disable iff (rst)
        unlock_clr |=> !unlock_clr); // R6

    AST_CLEAR_ENDS_WAIT: assert property (@(posedge clk) disable iff (rst)
        unlock_clr |-> ($past(busy) && !busy)); // R6

    AST_BUSY_BOUNDED: assert property (@(posedge clk) disable iff (rst)
        run_q <= CLK_PER_US); // R8

endmodule

bind pwd_guard pwd_guard_chk #(.CLK_PER_US(CLK_PER_US)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cmd_valid  (cmd_valid),
    .cmd_op     (cmd_op),
    .rd_data    (rd_data),
    .busy       (busy),
    .prog_err   (prog_err),
    .unlock_clr (unlock_clr),
    .sealed     (sealed_w),
    .words_flat (words_flat_w)
);

// File: tb/pwd_guard_bench.sv
module pwd_guard_bench;

    localparam int N = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = 2'd0;
    logic [1:0]  cmd_addr = 2'd0;
    logic [15:0] cmd_data = 16'h0;
    logic [15:0] rd_data;
    logic        busy;
    logic        prog_err;
    logic        unlock_clr;

    int checks = 0;
    int errors = 0;
    logic [15:0] exp_w [4];

    always #4 clk = ~clk;

    pwd_guard #(.CLK_PER_US(N)) u_pwd_guard (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data), .rd_data(rd_data),
        .busy(busy), .prog_err(prog_err), .unlock_clr(unlock_clr)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, expv);
        end
    endtask

    // Called at a falling edge; returns at the next falling edge.
    task automatic cmd(input logic [1:0] op, input logic [1:0] a, input logic [15:0] d);
        cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_data = d;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic read_chk(input string tag, input logic [1:0] a, input logic [15:0] expv);
        cmd(2'd1, a, 16'h0);
        check(tag, rd_data, expv);
    endtask

    // Four unlock words, addresses in the given order, data from the model.
    task automatic attempt(input logic [1:0] o0, o1, o2, o3, input logic [15:0] flip);
        cmd(2'd2, o0, exp_w[o0]);
        cmd(2'd2, o1, exp_w[o1]);
        cmd(2'd2, o2, exp_w[o2] ^ flip);
        cmd(2'd2, o3, exp_w[o3]);
    endtask

    // Samples from cycle k0 after the last word up to N+4; counts busy and pulses.
    task automatic watch(input int k0, output int nb, output int np, output int kp);
        nb = 0; np = 0; kp = -1;
        for (int k = k0; k <= N + 4; k++) begin
            if (busy) nb++;
            if (unlock_clr) begin np++; if (kp < 0) kp = k; end
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual hang expected finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int nb, np, kp;
        logic [1:0] ord [4];
        logic [15:0] d;
        logic e;
        ord[0] = 2'd2; ord[1] = 2'd0; ord[2] = 2'd3; ord[3] = 2'd1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 4; i++) exp_w[i] = 16'hFFFF;

        // R1 reset state
        check("R1 busy", busy, 0);
        check("R1 unlock_clr", unlock_clr, 0);
        check("R1 prog_err", prog_err, 0);
        for (int a = 0; a < 4; a++) read_chk("R1 erased read", 2'(a), 16'hFFFF);

        // R2/R3/R4 program sweep in scrambled order
        for (int p = 0; p < 8; p++) begin
            for (int j = 0; j < 4; j++) begin
                logic [1:0] a;
                a = ord[j];
                if (p % 2 == 0) d = exp_w[a] & ~(16'h1 << ((p * 5 + a * 3) % 16));
                else            d = ~(16'h1 << ((p * 7 + a) % 16));
                e = |(d & ~exp_w[a]);
                exp_w[a] = exp_w[a] & d;
                cmd(2'd0, a, d);
                check("R3 prog_err", prog_err, e);
                @(negedge clk);
                check("R3 prog_err one cycle", prog_err, 0);
                read_chk("R2 AND store", a, exp_w[a]);
            end
        end
        read_chk("R4 read addr0", 2'd0, exp_w[0]);
        @(negedge clk);
        check("R4 rd_data holds", rd_data, exp_w[0]);

        // R6 good attempt, timing
        attempt(2'd3, 2'd1, 2'd0, 2'd2, 16'h0);
        watch(1, nb, np, kp);
        check("R8 busy length", nb, N);
        check("R6 pulse count", np, 1);
        check("R6 pulse cycle", kp, N + 1);

        // R8 words during hold-off are dropped
        attempt(2'd0, 2'd1, 2'd2, 2'd3, 16'h0);
        attempt(2'd0, 2'd1, 2'd2, 2'd3, 16'h0);
        watch(5, nb, np, kp);
        check("R8 busy tail", nb, N - 4);
        check("R8 single pulse", np, 1);
        check("R8 dropped no attempt", busy, 0);
        attempt(2'd2, 2'd3, 2'd1, 2'd0, 16'h0);
        watch(1, nb, np, kp);
        check("R8 clean after drop", np, 1);

        // R7 mismatch and repeated address
        attempt(2'd0, 2'd1, 2'd2, 2'd3, 16'h0040);
        watch(1, nb, np, kp);
        check("R7 mismatch busy", nb, N);
        check("R7 mismatch no pulse", np, 0);
        cmd(2'd2, 2'd0, exp_w[0]);
        cmd(2'd2, 2'd1, exp_w[1]);
        cmd(2'd2, 2'd1, exp_w[1]);
        cmd(2'd2, 2'd3, exp_w[3]);
        watch(1, nb, np, kp);
        check("R7 duplicate busy", nb, N);
        check("R7 duplicate no pulse", np, 0);

        // R9 other command aborts partial attempt
        cmd(2'd2, 2'd0, exp_w[0]);
        cmd(2'd2, 2'd1, exp_w[1]);
        cmd(2'd2, 2'd2, exp_w[2]);
        cmd(2'd1, 2'd0, 16'h0);
        cmd(2'd2, 2'd3, exp_w[3]);
        @(negedge clk);
        check("R9 abort no hold-off", busy, 0);
        cmd(2'd1, 2'd0, 16'h0);
        attempt(2'd1, 2'd0, 2'd3, 2'd2, 16'h0);
        watch(1, nb, np, kp);
        check("R9 fresh attempt pulse", np, 1);

        // R5 seal
        cmd(2'd3, 2'd0, 16'h0);
        for (int a = 0; a < 4; a++) read_chk("R5 sealed read blank", 2'(a), 16'h0);
        cmd(2'd0, 2'd0, 16'hFFFF);
        check("R5 sealed no prog_err", prog_err, 0);
        cmd(2'd0, 2'd1, 16'h0000);
        check("R5 sealed no prog_err 2", prog_err, 0);
        attempt(2'd0, 2'd1, 2'd2, 2'd3, 16'h0);
        watch(1, nb, np, kp);
        check("R5 sealed unlock with old password", np, 1);
        check("R5 sealed pulse cycle", kp, N + 1);

        // R1 reset restores erased, unsealed state
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 4; i++) exp_w[i] = 16'hFFFF;
        read_chk("R1 reset read", 2'd3, 16'hFFFF);
        cmd(2'd0, 2'd3, 16'h1234);
        check("R1 reset prog ok", prog_err, 0);
        read_chk("R1 reset unsealed", 2'd3, 16'h1234);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule